// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This block converts a stream of pixels with four 8-bit channels (alpha, red, green, blue) into 32-bit memory words in one of several output layouts. These are 16-bit layouts with 4 bits per channel, 16-bit 5-6-5 layouts, 24-bit packed layouts and 32-bit layouts. A 4-bit format code selects both the layout and the order of the channels. Narrow channels are made by keeping the most significant bits of each 8-bit channel.

Alpha is handled by two configuration bits. When alpha storage is on, the pixel's alpha is stored, and is inverted if the invert bit is set. When it is off, the alpha field is filled with all ones if the invert bit is clear, or all zeros if it is set. A 4-bit lane mask can suppress stores to single byte lanes of every output word.

Pixels enter on a valid/ready handshake with an end-of-line marker. Words leave on a valid/ready handshake with one strobe per byte lane. Small pixels are gathered into full words. At the end of a line, any partly filled word is sent out with strobes only on the bytes that hold data. The configuration must stay constant within a line.

Top module: `pix_pack`

## Requirements
- R1: After synchronous reset, out_valid is low and in_ready is high.
- R2: Format codes 12..15 produce one 32-bit word per pixel. Listed from byte 3 down to byte 0, the channels are: 12 = A,B,G,R; 13 = A,R,G,B; 14 = B,G,R,A; 15 = R,G,B,A.
- R3: With alpha_en high, the stored alpha equals the pixel alpha XOR {8{alpha_inv}}.
- R4: With alpha_en low, the alpha field is all ones when alpha_inv is 0 and all zeros when alpha_inv is 1.
- R5: Codes 0..3 produce 16-bit pixels. Each channel keeps its top 4 bits. Nibbles are ordered from bit 15 down to bit 0 as: 0 = A,B,G,R; 1 = A,R,G,B; 2 = B,G,R,A; 3 = R,G,B,A. Two pixels share one word, with the first pixel in bits 15:0.
- R6: Code 7 packs R[7:3] into bits 15:11, G[7:2] into bits 10:5 and B[7:3] into bits 4:0. Code 6 uses the same layout with B and R swapped. Words are packed two pixels per word, as in R5.
- R7: Codes 8 and 9 produce 3-byte pixels. From byte 2 down to byte 0, the bytes are: 9 = R,G,B; 8 = B,G,R. The pixels form a little-endian byte stream, so four pixels fill exactly three words.
- R8: On a pixel marked last, any partly filled word is emitted with strobes set only on its filled low lanes, and unfilled lanes read zero. If the last pixel overflows a full word, a second word follows, and no input is taken until it has been sent.
- R9: out_strb is the bitwise AND of the lanes holding data and byte_en. Bit i of byte_en gates byte lane i (bits 8i+7:8i).
- R10: The unused codes 4, 5, 10 and 11 emit one word per pixel with data 0 and out_strb 0.
- R11: While out_valid is high and out_ready is low, out_data and out_strb stay stable and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 32 | Pixel {A,R,G,B}, 8 bits each, A in bits 31:24 |
| in_last | input | 1 | Pixel is the last of its line |
| fmt | input | 4 | Output format code |
| alpha_en | input | 1 | Store pixel alpha instead of a fill value |
| alpha_inv | input | 1 | Invert stored alpha, or select the fill value |
| byte_en | input | 4 | Per-lane store enables |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Packed memory word |
| out_strb | output | 4 | Byte strobes, bit i for bits 8i+7:8i |

## Verification
The directed tests target the byte stream of the 24-bit layouts. A two-pixel line forces an overflow flush. In that case a design that drops the held bytes, or accepts a new pixel during the flush, loses or misplaces the final two bytes. Short 16-bit lines check that a lone pixel gets strobes on only the low two lanes, not a full word with stale upper data. Inverted and filled alpha, per-lane masking and the unused codes are each compared with computed words, so a swapped fill polarity or a leaked strobe shows up as a wrong value. A stall with out_ready held low checks that the pending word neither changes nor lets another pixel in.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

    localparam int CH_W   = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = CH_W * LANES;
    localparam int HOLD_W = CH_W * (LANES - 1);
    localparam int COMB_W = CH_W * (2 * LANES - 1);
    localparam int CNT_W  = $clog2(LANES);
    localparam int NB_W   = $clog2(LANES) + 1;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pix_t;

    // One converted pixel: bytes right-aligned, byte count, legal code flag
    typedef struct packed {
        logic [WORD_W-1:0] bytes;
        logic [NB_W-1:0]   nbytes;
        logic              legal;
    } conv_t;

    // Four-channel ordering, high byte first
    function automatic logic [31:0] order4(input logic [1:0] sel,
                                           input logic [7:0] a, r, g, b);
        case (sel)
            2'd0:    order4 = {a, b, g, r};
            2'd1:    order4 = {a, r, g, b};
            2'd2:    order4 = {b, g, r, a};
            default: order4 = {r, g, b, a};
        endcase
    endfunction

    // Three-channel ordering, high byte first
    function automatic logic [23:0] order3(input logic rgb_first,
                                           input logic [7:0] r, g, b);
        order3 = rgb_first ? {r, g, b} : {b, g, r};
    endfunction

    function automatic logic [15:0] fold4444(input logic [31:0] w);
        fold4444 = {w[31:28], w[23:20], w[15:12], w[7:4]};
    endfunction

    function automatic logic [15:0] fold565(input logic [23:0] w);
        fold565 = {w[23:19], w[15:10], w[7:3]};
    endfunction

    // Strobe mask for the low n lanes
    function automatic logic [LANES-1:0] low_lanes(input logic [NB_W-1:0] n);
        logic [LANES-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++)
            if (i < int'(n)) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/px_format.sv
module px_format
    import pxp_pkg::*;
(
    input  pix_t        pix,
    input  logic [3:0]  fmt,
    input  logic        alpha_en,
    input  logic        alpha_inv,
    output conv_t       conv
);

    logic [CH_W-1:0] alpha_v;
    logic [31:0]     four_ch;
    logic [23:0]     three_ch;

    always_comb begin
        alpha_v  = alpha_en ? (pix.a ^ {CH_W{alpha_inv}}) : {CH_W{~alpha_inv}};
        four_ch  = order4(fmt[1:0], alpha_v, pix.r, pix.g, pix.b);
        three_ch = order3(fmt[0], pix.r, pix.g, pix.b);
    end

    always_comb begin
        conv = '0;
        case (fmt[3:2])
            2'b00: begin
                conv.bytes  = {16'h0, fold4444(four_ch)};
                conv.nbytes = NB_W'(2);
                conv.legal  = 1'b1;
            end
            2'b01: begin
                conv.nbytes = NB_W'(fmt[1] ? 2 : 4);
                conv.legal  = fmt[1];
                if (fmt[1]) conv.bytes = {16'h0, fold565(three_ch)};
            end
            2'b10: begin
                conv.nbytes = NB_W'(fmt[1] ? 4 : 3);
                conv.legal  = ~fmt[1];
                if (!fmt[1]) conv.bytes = {8'h0, three_ch};
            end
            default: begin
                conv.bytes  = four_ch;
                conv.nbytes = NB_W'(4);
                conv.legal  = 1'b1;
            end
        endcase
    end

    // r10_: illegal codes never carry data
    always_comb begin
        if (!conv.legal)
            p_illegal_zero_r10: assert (conv.bytes == '0);
    end

endmodule

// File: rtl/px_accum.sv
module px_accum
    import pxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  conv_t             conv,
    input  logic [LANES-1:0]  byte_en,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb
);

    logic [HOLD_W-1:0] held_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flush_q;
    logic              ov_q;
    logic [WORD_W-1:0] data_q;
    logic [LANES-1:0]  strb_q;

    logic              slot_free;
    logic              take;
    logic [COMB_W-1:0] comb;
    logic [NB_W-1:0]   tot;
    logic              full;

    always_comb begin
        slot_free = !ov_q || out_ready;
        in_ready  = slot_free && !flush_q;
        take      = in_valid && in_ready;
        comb      = (COMB_W'(conv.bytes) << {cnt_q, 3'b000}) | COMB_W'(held_q);
        tot       = NB_W'(cnt_q) + conv.nbytes;
        full      = tot[NB_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            cnt_q   <= '0;
            flush_q <= 1'b0;
            ov_q    <= 1'b0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            if (slot_free) ov_q <= 1'b0;
            if (flush_q && slot_free) begin
                ov_q    <= 1'b1;
                data_q  <= WORD_W'(held_q);
                strb_q  <= low_lanes(NB_W'(cnt_q)) & byte_en;
                held_q  <= '0;
                cnt_q   <= '0;
                flush_q <= 1'b0;
            end else if (take) begin
                if (full) begin
                    ov_q    <= 1'b1;
                    data_q  <= comb[WORD_W-1:0];
                    strb_q  <= byte_en & {LANES{conv.legal}};
                    held_q  <= comb[COMB_W-1:WORD_W];
                    cnt_q   <= tot[CNT_W-1:0];
                    flush_q <= in_last && (tot[CNT_W-1:0] != '0);
                end else if (in_last) begin
                    ov_q    <= 1'b1;
                    data_q  <= comb[WORD_W-1:0];
                    strb_q  <= low_lanes(tot) & byte_en & {LANES{conv.legal}};
                    held_q  <= '0;
                    cnt_q   <= '0;
                end else begin
                    held_q  <= comb[HOLD_W-1:0];
                    cnt_q   <= tot[CNT_W-1:0];
                end
            end
        end
    end

    assign out_valid = ov_q;
    assign out_data  = data_q;
    assign out_strb  = strb_q;

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !out_ready) |=> (ov_q && $stable(data_q) && $stable(strb_q)));

    p_stall_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        (ov_q && !out_ready) |-> !in_ready);

    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> !in_ready);

    p_strb_masked_r9: assert property (@(posedge clk) disable iff (rst)
        ov_q |-> ((strb_q & ~byte_en) == '0));

endmodule

// File: rtl/pix_pack.sv
module pix_pack
    import pxp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_pix,
    input  logic        in_last,
    input  logic [3:0]  fmt,
    input  logic        alpha_en,
    input  logic        alpha_inv,
    input  logic [3:0]  byte_en,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic [3:0]  out_strb
);

    pix_t  pix;
    conv_t conv;

    assign pix = pix_t'(in_pix);

    px_format u_fmt (
        .pix       (pix),
        .fmt       (fmt),
        .alpha_en  (alpha_en),
        .alpha_inv (alpha_inv),
        .conv      (conv)
    );

    px_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .conv      (conv),
        .byte_en   (byte_en),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_strb  (out_strb)
    );

endmodule

// File: tb/tb_pix_pack.sv
module tb_pix_pack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pix = '0;
    logic        in_last = 1'b0;
    logic [3:0]  fmt = 4'd13;
    logic        alpha_en = 1'b1;
    logic        alpha_inv = 1'b0;
    logic [3:0]  byte_en = 4'hF;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_strb;

    int n_chk = 0;
    int n_fail = 0;
    logic [35:0] got[$];

    localparam logic [31:0] P0 = 32'h81123456;
    localparam logic [31:0] P1 = 32'h7EABCDEF;
    localparam logic [31:0] P2 = 32'h11223344;
    localparam logic [31:0] P3 = 32'h55667788;

    always #2 clk = ~clk;

    pix_pack dut (.*);

    always @(negedge clk)
        if (!rst && out_valid && out_ready) got.push_back({out_strb, out_data});

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_count(input string req, input int exp);
        chk(got.size() == exp, req, "word count", got.size(), exp);
    endtask

    task automatic chk_word(input string req, input int idx,
                            input logic [31:0] ed, input logic [3:0] es);
        if (idx >= got.size()) begin
            chk(1'b0, req, "missing word", 32'(idx), 32'(got.size()));
        end else begin
            chk(got[idx][31:0] == ed, req, "data", got[idx][31:0], ed);
            chk(got[idx][35:32] == es, req, "strobe", 32'(got[idx][35:32]), 32'(es));
        end
    endtask

    task automatic cfg(input logic [3:0] f, input logic ae, input logic ai,
                       input logic [3:0] be);
        @(posedge clk); #1;
        fmt = f; alpha_en = ae; alpha_inv = ai; byte_en = be;
        got.delete();
    endtask

    task automatic push(input logic [31:0] p, input logic last);
        bit acc;
        in_valid = 1'b1; in_pix = p; in_last = last;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
    endtask

    task automatic t_rgb32();
        cfg(4'd13, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b0); push(P1, 1'b1); drain();
        chk_count("R2", 2);
        chk_word("R2", 0, 32'h81123456, 4'hF);
        chk_word("R2", 1, 32'h7EABCDEF, 4'hF);
        cfg(4'd12, 1'b1, 1'b1, 4'hF);
        push(P0, 1'b1); drain();
        chk_word("R3", 0, 32'h7E563412, 4'hF);
    endtask

    task automatic t_alpha_fill();
        cfg(4'd15, 1'b0, 1'b0, 4'hF);
        push(P0, 1'b1); drain();
        chk_word("R4", 0, 32'h123456FF, 4'hF);
        cfg(4'd14, 1'b0, 1'b1, 4'hF);
        push(P0, 1'b1); drain();
        chk_word("R4", 0, 32'h56341200, 4'hF);
    endtask

    task automatic t_4444();
        cfg(4'd1, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b0); push(P1, 1'b1); drain();
        chk_count("R5", 1);
        chk_word("R5", 0, 32'h7ACE8135, 4'hF);
        cfg(4'd2, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b1); drain();
        chk_word("R8", 0, 32'h00005318, 4'h3);
    endtask

    task automatic t_565();
        cfg(4'd7, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b0); push(P1, 1'b0); push(P2, 1'b1); drain();
        chk_count("R6", 2);
        chk_word("R6", 0, 32'hAE7D11AA, 4'hF);
        chk_word("R8", 1, 32'h00002188, 4'h3);
        cfg(4'd6, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b1); drain();
        chk_word("R6", 0, 32'h000051A2, 4'h3);
    endtask

    task automatic t_888();
        cfg(4'd9, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b0); push(P1, 1'b0); push(P2, 1'b0); push(P3, 1'b1); drain();
        chk_count("R7", 3);
        chk_word("R7", 0, 32'hEF123456, 4'hF);
        chk_word("R7", 1, 32'h3344ABCD, 4'hF);
        chk_word("R7", 2, 32'h66778822, 4'hF);
        cfg(4'd8, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b0); push(P1, 1'b1); drain();
        chk_count("R8", 2);
        chk_word("R8", 0, 32'hAB563412, 4'hF);
        chk_word("R8", 1, 32'h0000EFCD, 4'h3);
    endtask

    task automatic t_byte_en();
        cfg(4'd13, 1'b1, 1'b0, 4'b0101);
        push(P0, 1'b1); drain();
        chk_word("R9", 0, 32'h81123456, 4'b0101);
        cfg(4'd9, 1'b1, 1'b0, 4'b1110);
        push(P0, 1'b1); drain();
        chk_word("R9", 0, 32'h00123456, 4'b0110);
    endtask

    task automatic t_unused();
        cfg(4'd5, 1'b1, 1'b0, 4'hF);
        push(P0, 1'b1); drain();
        chk_count("R10", 1);
        chk_word("R10", 0, 32'h0, 4'h0);
        cfg(4'd11, 1'b1, 1'b0, 4'hF);
        push(P1, 1'b0); push(P2, 1'b1); drain();
        chk_count("R10", 2);
        chk_word("R10", 1, 32'h0, 4'h0);
    endtask

    task automatic t_stall();
        cfg(4'd13, 1'b1, 1'b0, 4'hF);
        out_ready = 1'b0;
        push(P0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R11", "valid held", 32'(out_valid), 1);
        chk(out_data == 32'h81123456, "R11", "data held", out_data, 32'h81123456);
        chk(in_ready == 1'b0, "R11", "input blocked", 32'(in_ready), 0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        push(P1, 1'b1); drain();
        chk_count("R11", 2);
        chk_word("R11", 0, 32'h81123456, 4'hF);
        chk_word("R11", 1, 32'h7EABCDEF, 4'hF);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_rgb32();
        t_alpha_fill();
        t_4444();
        t_565();
        t_888();
        t_byte_en();
        t_unused();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule